// File: doc/BRIEF.md
# Almost-Full/Empty Offset Programmer

This block sets the two threshold offsets that a FIFO's partial-flag logic compares against. One offset is for almost-empty (X) and one is for almost-full (Y). A three-pin select code is held while reset is asserted. The value present at the last write-clock edge before reset is released fixes the loading method until the next reset. The code either picks one of five fixed offsets for both registers, or opens a programming phase. In that phase the offsets arrive bit by bit on a serial data/enable pair, or come from the first two words written on the FIFO write port.

The block sits between the write port and the FIFO storage. While programming is in progress, an input-ready output holds back ordinary data. Once the offsets are in place, it passes write strobes through as store strobes. Every loaded value is forced into the legal window of 1 to depth-4. A flag output reports whether the parallel load skips data bit 8, which is the interspersed-parity layout.

Top module: `offset_prog`

## Requirements
- R1: While rst_n is low, in_ready and data_wr are low, and ofs_x and ofs_y read 0.
- R2: Select codes sel[2:0] (1 = high) 3'b111, 3'b110, 3'b101, 3'b011 and 3'b001 load 64, 16, 8, 256 and 1024 respectively into both ofs_x and ofs_y. After the first clk edge following reset release, in_ready is high.
- R3: The code used is the sel value at the last clk edge while rst_n is low. Changes to sel after release have no effect.
- R4: Code 3'b010 selects serial loading. From the second clk edge after release, each edge with ser_en_n low shifts in ser_d, most significant bit first. The first log2(DEPTH) bits form Y and the next log2(DEPTH) bits form X. Edges with ser_en_n high shift nothing.
- R5: In serial mode, in_ready stays low until the clk edge that takes the final bit and is high after that edge. The offsets remain 0 until that edge.
- R6: Codes 3'b100 and 3'b000 select parallel loading, with in_ready high from the first edge after release. The first accepted write loads Y, the second loads X, and only later writes raise data_wr.
- R7: For code 3'b100 the offset is wr_data[log2(DEPTH)-1:0]. For code 3'b000 it is {wr_data[log2(DEPTH):9], wr_data[7:0]}, and wr_data[8] is ignored.
- R8: A loaded value of 0 becomes 1, and a value above DEPTH-4 becomes DEPTH-4, in every loading method.
- R9: parity_il is high only for code 3'b000 and does not change after reset release.
- R10: data_wr equals wr_en once programming is complete and is low before that, including during serial loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low reset; select code captured while low |
| sel | input | 3 | Loading method / preset select code |
| ser_d | input | 1 | Serial offset data |
| ser_en_n | input | 1 | Serial shift enable, active low |
| wr_en | input | 1 | Write strobe of the FIFO write port |
| wr_data | input | DATA_W | Write data of the FIFO write port |
| ofs_x | output | log2(DEPTH) | Almost-empty offset |
| ofs_y | output | log2(DEPTH) | Almost-full offset |
| in_ready | output | 1 | Write port ready; low during reset and serial loading |
| data_wr | output | 1 | Store strobe to FIFO storage after programming |
| parity_il | output | 1 | Interspersed-parity layout selected |

## Verification
The hardest case to reach is the serial stream's final edge. There the input-ready output must rise, both clamped offsets must appear together, and a write presented on that same edge must still be refused. Reaching it takes 28 enabled edges after a reset with the serial code. The stimulus shifts a word whose X half exceeds the legal range, and it inserts a disabled edge with toggling data partway through to show the idle edge is skipped. The bench raises wr_en just before the final bit and samples in_ready and data_wr on both sides of that edge.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;
   typedef enum logic [2:0] {
      ST_INIT,
      ST_SER,
      ST_PAR_Y,
      ST_PAR_X,
      ST_RUN
   } ofs_state_e;

   typedef enum logic [1:0] {
      M_PRESET,
      M_SERIAL,
      M_PAR_FLAT,
      M_PAR_IL
   } ofs_mode_e;
endpackage

// File: rtl/ofs_sel_decode.sv
module ofs_sel_decode
   import ofs_prog_pkg::*;
#(
   parameter int OFS_W = 14
) (
   input  logic [2:0]       sel,
   output ofs_mode_e        mode,
   output logic [OFS_W-1:0] preset
);
   always_comb begin
      mode   = M_PRESET;
      preset = '0;
      unique case (sel)
         3'b111: preset = OFS_W'(64);
         3'b110: preset = OFS_W'(16);
         3'b101: preset = OFS_W'(8);
         3'b011: preset = OFS_W'(256);
         3'b001: preset = OFS_W'(1024);
         3'b010: mode   = M_SERIAL;
         3'b100: mode   = M_PAR_FLAT;
         default: mode  = M_PAR_IL;
      endcase
   end
endmodule

// File: rtl/ofs_word_pick.sv
module ofs_word_pick #(
   parameter int DATA_W = 36,
   parameter int OFS_W  = 14
) (
   input  logic [DATA_W-1:0] data,
   input  logic              il,
   output logic [OFS_W-1:0]  val
);
   logic [OFS_W-1:0] flat_v;
   logic [OFS_W-1:0] il_v;

   generate
      if (OFS_W < 9 || DATA_W < OFS_W + 1) begin : g_bad
         $error("ofs_word_pick: DATA_W must exceed OFS_W and OFS_W must be at least 9");
      end
   endgenerate

   assign flat_v = data[OFS_W-1:0];
   assign il_v   = {data[OFS_W:9], data[7:0]};
   assign val    = il ? il_v : flat_v;

   logic unused_data;
   assign unused_data = ^data;
endmodule

// File: rtl/ofs_serial_shift.sv
module ofs_serial_shift #(
   parameter int OFS_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             ser_d,
   input  logic             ser_en_n,
   output logic             done,
   output logic [2*OFS_W-1:0] word
);
   localparam int NBITS = 2 * OFS_W;
   localparam int CW    = $clog2(NBITS);
   localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

   logic [NBITS-1:0] sh_q;
   logic [CW-1:0]    cnt_q;
   logic             take;

   assign take = active && !ser_en_n;
   assign word = {sh_q[NBITS-2:0], ser_d};
   assign done = take && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (take) begin
         sh_q  <= word;
         cnt_q <= done ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/offset_prog.sv
module offset_prog
   import ofs_prog_pkg::*;
#(
   parameter int DEPTH  = 16384,
   parameter int DATA_W = 36
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [2:0]                 sel,
   input  logic                       ser_d,
   input  logic                       ser_en_n,
   input  logic                       wr_en,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [$clog2(DEPTH)-1:0]   ofs_x,
   output logic [$clog2(DEPTH)-1:0]   ofs_y,
   output logic                       in_ready,
   output logic                       data_wr,
   output logic                       parity_il
);
   localparam int OFS_W = $clog2(DEPTH);
   localparam logic [OFS_W-1:0] LIM = OFS_W'(DEPTH - 4);

   generate
      if (DEPTH < 2048 || (1 << OFS_W) != DEPTH) begin : g_bad_depth
         $error("offset_prog: DEPTH must be a power of two of at least 2048");
      end
   endgenerate

   function automatic logic [OFS_W-1:0] fit(input logic [OFS_W-1:0] v);
      if (v == '0)  return OFS_W'(1);
      if (v > LIM)  return LIM;
      return v;
   endfunction

   logic [2:0]         sel_q;
   ofs_mode_e          mode;
   logic [OFS_W-1:0]   preset;
   logic [OFS_W-1:0]   picked;
   logic               ser_done;
   logic [2*OFS_W-1:0] ser_word;
   ofs_state_e         st_q;
   logic               st_run;
   logic               st_ser;

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= sel;
   end

   ofs_sel_decode #(.OFS_W(OFS_W)) u_dec (
      .sel    (sel_q),
      .mode   (mode),
      .preset (preset)
   );

   ofs_word_pick #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_pick (
      .data (wr_data),
      .il   (parity_il),
      .val  (picked)
   );

   ofs_serial_shift #(.OFS_W(OFS_W)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (st_ser),
      .ser_d    (ser_d),
      .ser_en_n (ser_en_n),
      .done     (ser_done),
      .word     (ser_word)
   );

   assign parity_il = (mode == M_PAR_IL);
   assign st_run    = (st_q == ST_RUN);
   assign st_ser    = (st_q == ST_SER);
   assign in_ready  = st_run || (st_q == ST_PAR_Y) || (st_q == ST_PAR_X);
   assign data_wr   = wr_en && st_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_INIT;
         ofs_x <= '0;
         ofs_y <= '0;
      end else begin
         unique case (st_q)
            ST_INIT: begin
               unique case (mode)
                  M_PRESET: begin
                     ofs_x <= fit(preset);
                     ofs_y <= fit(preset);
                     st_q  <= ST_RUN;
                  end
                  M_SERIAL: st_q <= ST_SER;
                  default:  st_q <= ST_PAR_Y;
               endcase
            end
            ST_SER: if (ser_done) begin
               ofs_y <= fit(ser_word[2*OFS_W-1:OFS_W]);
               ofs_x <= fit(ser_word[OFS_W-1:0]);
               st_q  <= ST_RUN;
            end
            ST_PAR_Y: if (wr_en) begin
               ofs_y <= fit(picked);
               st_q  <= ST_PAR_X;
            end
            ST_PAR_X: if (wr_en) begin
               ofs_x <= fit(picked);
               st_q  <= ST_RUN;
            end
            default: st_q <= ST_RUN;
         endcase
      end
   end
endmodule

// File: rtl/offset_prog_chk.sv
module offset_prog_chk #(
   parameter int DEPTH = 16384
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_ready,
   input logic                     data_wr,
   input logic                     parity_il,
   input logic [$clog2(DEPTH)-1:0] ofs_x,
   input logic [$clog2(DEPTH)-1:0] ofs_y,
   input logic                     st_run,
   input logic                     st_ser
);
   localparam int OFS_W = $clog2(DEPTH);
   localparam logic [OFS_W-1:0] LIM = OFS_W'(DEPTH - 4);

   // R10: nothing is stored before programming ends
   a_r10_store_gated: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |-> (in_ready && st_run));

   // R8: offsets inside the legal window once loaded
   a_r8_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      st_run |-> (ofs_x != '0 && ofs_x <= LIM && ofs_y != '0 && ofs_y <= LIM));

   // R3: loaded offsets do not move
   a_r3_offsets_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      st_run |=> ($stable(ofs_x) && $stable(ofs_y)));

   // R5: port held off while bits are arriving
   a_r5_serial_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      st_ser |-> !in_ready);

   // R9: parity layout flag fixed after release
   a_r9_layout_stable: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(parity_il));
endmodule

bind offset_prog offset_prog_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .data_wr   (data_wr),
   .parity_il (parity_il),
   .ofs_x     (ofs_x),
   .ofs_y     (ofs_y),
   .st_run    (st_run),
   .st_ser    (st_ser)
);

// File: tb/tb_offset_prog.sv
`timescale 1ns/1ps
module tb_offset_prog;
   localparam int DEPTH  = 16384;
   localparam int DATA_W = 36;
   localparam int OW     = 14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        sel = 3'b111;
   logic              ser_d = 1'b0;
   logic              ser_en_n = 1'b1;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [OW-1:0]     ofs_x, ofs_y;
   logic              in_ready, data_wr, parity_il;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   offset_prog #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .ser_d(ser_d), .ser_en_n(ser_en_n),
      .wr_en(wr_en), .wr_data(wr_data), .ofs_x(ofs_x), .ofs_y(ofs_y),
      .in_ready(in_ready), .data_wr(data_wr), .parity_il(parity_il)
   );

   localparam logic [2:0] CODES [5] = '{3'b111, 3'b110, 3'b101, 3'b011, 3'b001};
   localparam int         VALS  [5] = '{64, 16, 8, 256, 1024};

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] code);
      rst_n = 1'b0; wr_en = 1'b0; ser_en_n = 1'b1; sel = code;
      tick(); tick(); tick();
      chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
      chk(ofs_x == '0 && ofs_y == '0, "R1 offsets", int'(ofs_x), 0);
      rst_n = 1'b1;
      tick();
   endtask

   initial begin
      logic [2*OW-1:0] w;
      // preset table walk (R2, R3, R9)
      for (int i = 0; i < 5; i++) begin
         do_reset(CODES[i]);
         sel = ~CODES[i];
         tick();
         chk(ofs_x == OW'(VALS[i]), "R2 preset x", int'(ofs_x), VALS[i]);
         chk(ofs_y == OW'(VALS[i]), "R2 preset y", int'(ofs_y), VALS[i]);
         chk(in_ready == 1'b1, "R2 ready", int'(in_ready), 1);
         chk(parity_il == 1'b0, "R9 flag low", int'(parity_il), 0);
      end

      // R3: last value during reset wins
      rst_n = 1'b0; sel = 3'b000; tick(); tick();
      sel = 3'b001; tick();
      rst_n = 1'b1; sel = 3'b111; tick(); tick();
      chk(ofs_x == OW'(1024), "R3 last sel wins", int'(ofs_x), 1024);
      chk(parity_il == 1'b0, "R3 flag", int'(parity_il), 0);

      // serial (R4, R5, R8, R10)
      do_reset(3'b010);
      chk(in_ready == 1'b0, "R5 low at start", int'(in_ready), 0);
      w = {OW'(5), OW'(16383)};
      for (int b = 2*OW-1; b >= 0; b--) begin
         ser_en_n = 1'b0; ser_d = w[b];
         if (b == 0) begin
            wr_en = 1'b1;
            chk(in_ready == 1'b0, "R5 low before last", int'(in_ready), 0);
            chk(data_wr == 1'b0, "R10 blocked in serial", int'(data_wr), 0);
            chk(ofs_y == '0, "R5 y not yet", int'(ofs_y), 0);
         end
         tick();
         if (b == OW) begin
            ser_en_n = 1'b1; ser_d = ~ser_d;
            tick();
         end
      end
      ser_en_n = 1'b1;
      chk(in_ready == 1'b1, "R5 high after last", int'(in_ready), 1);
      chk(ofs_y == OW'(5), "R4 serial y", int'(ofs_y), 5);
      chk(ofs_x == OW'(16380), "R8 serial x clamp", int'(ofs_x), 16380);
      chk(data_wr == 1'b1, "R10 pass", int'(data_wr), 1);
      wr_en = 1'b0; tick();

      // parallel contiguous (R6, R7, R8)
      do_reset(3'b100);
      chk(in_ready == 1'b1, "R6 ready", int'(in_ready), 1);
      chk(parity_il == 1'b0, "R9 flat flag", int'(parity_il), 0);
      wr_en = 1'b1; wr_data = (36'h5 << 20) | 36'd100;
      chk(data_wr == 1'b0, "R6 first not stored", int'(data_wr), 0);
      tick();
      chk(ofs_y == OW'(100), "R7 flat y", int'(ofs_y), 100);
      wr_data = 36'h3_0000_C000;
      chk(data_wr == 1'b0, "R6 second not stored", int'(data_wr), 0);
      tick();
      chk(ofs_x == OW'(1), "R8 zero clamp", int'(ofs_x), 1);
      wr_data = 36'd777;
      chk(data_wr == 1'b1, "R6 third stored", int'(data_wr), 1);
      tick();
      chk(ofs_y == OW'(100) && ofs_x == OW'(1), "R6 unchanged", int'(ofs_y), 100);
      wr_en = 1'b0;

      // parallel interspersed (R7, R8, R9)
      do_reset(3'b000);
      chk(parity_il == 1'b1, "R9 il flag", int'(parity_il), 1);
      wr_en = 1'b1;
      wr_data = (36'd1 << 20) | (36'd11 << 9) | (36'd1 << 8) | 36'hB8;
      tick();
      chk(ofs_y == OW'(3000), "R7 il y bit8 ignored", int'(ofs_y), 3000);
      wr_data = (36'd63 << 9) | 36'hFF;
      tick();
      chk(ofs_x == OW'(16380), "R8 il x clamp", int'(ofs_x), 16380);
      chk(data_wr == 1'b1, "R10 run", int'(data_wr), 1);
      wr_en = 1'b0;
      tick();

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule